// File: doc/BRIEF.md
# Flash Status Auto-Polling Matcher

This block watches a serial flash's status without software in the loop. Once started, it asks a serial command engine to run a status-read command. It gathers the 1 to 4 status bytes that come back and tests them against a programmed mask and expected value. The test combines the selected bits either all-must-agree or any-may-agree. When the test passes, a sticky match flag is raised.

Between reads it waits a programmable number of clock cycles. It can stop on its own at the first match, or keep polling until it is aborted. An abort lets any read already in flight run to its end, then returns the block to idle with a one-cycle completion pulse.

The configuration is sampled when `start` is accepted and stays fixed for the whole polling run. The command engine sees a simple request held until acknowledged, followed by a byte stream.

Top module: `status_poller`

## Requirements
- R1: After synchronous reset, `busy`, `rd_req`, `match_flag` and `done_pulse` are all low.
- R2: A `start` seen while idle raises `busy` and `rd_req` after the next edge. `rd_req` stays high until an edge at which `rd_ack` is high, and is low from the following edge. `start` while busy has no effect.
- R3: A read carries `cfg_bytes_m1`+1 bytes (field value 0..3 means 1..4 bytes), taken on cycles with `rx_valid` high. Byte k (k counted from 0 in arrival order) occupies bits 8k+7..8k of the compared value.
- R4: In all-agree mode (`cfg_any_mode`=0) a read matches when every selected bit equals the same bit of `cfg_expect`. With no bit selected, the read matches.
- R5: In any-agree mode (`cfg_any_mode`=1) a read matches when at least one selected bit equals its expected bit. With no bit selected, the read does not match.
- R6: A bit of `cfg_mask` is selected only when it is set and lies below 8×(byte count). Mask and expected bits at or above that position have no effect.
- R7: With interval I, `rd_req` rises I+1 edges after the edge that takes the last byte of a read that neither stopped nor was aborted.
- R8: With `cfg_auto_stop`=1, a matching read ends polling: `busy` falls and `match_flag` rises at the same edge, one edge after the last byte.
- R9: With `cfg_auto_stop`=0, polling continues after a match, and every matching read sets `match_flag` again.
- R10: `match_flag` stays high until `match_clr` is sampled high. A match in the same cycle as `match_clr` keeps the flag high.
- R11: An abort sampled while waiting for an acknowledge or between reads returns the block to idle at that edge. `done_pulse` is then high for exactly one cycle.
- R12: An abort sampled during a read lets the read finish and be evaluated. The block goes idle, with `done_pulse` high for one cycle, one edge after the last byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin polling (accepted only while idle) |
| abort | input | 1 | Stop polling after any read in flight |
| cfg_mask | input | 32 | Selects compared status bits |
| cfg_expect | input | 32 | Expected level of each selected bit |
| cfg_any_mode | input | 1 | 0: all selected bits must agree, 1: any one suffices |
| cfg_auto_stop | input | 1 | Stop at the first matching read |
| cfg_interval | input | 16 | Idle cycles between reads |
| cfg_bytes_m1 | input | 2 | Status byte count minus one |
| rd_req | output | 1 | Request a status read from the command engine |
| rd_ack | input | 1 | Engine accepted the request |
| rx_valid | input | 1 | A status byte is present on rx_byte |
| rx_byte | input | 8 | Received status byte |
| match_clr | input | 1 | Clears the match flag |
| match_flag | output | 1 | Sticky status-match flag |
| busy | output | 1 | Polling run in progress |
| done_pulse | output | 1 | One-cycle pulse when an abort completes |

## Verification
Every result here is registered, so each one appears a fixed number of edges after its cause. `busy` and `rd_req` follow `start` or `rd_ack` by one edge. `match_flag`, an automatic stop and a deferred abort follow the last status byte by one edge. The next request follows by I+1 edges, and an abort outside a read takes effect at its own sampling edge. A behavioural model in the bench steps on the same edges and is compared at every falling edge. Directed checks count falling edges from a known event to the cycle these rules predict. The bench drives all inputs away from the rising edge, so each sample sees settled values.

// File: rtl/stpoll_pkg.sv
package stpoll_pkg;

    localparam int BYTE_W   = 8;
    localparam int STAT_BYTES = 4;
    localparam int STAT_W   = BYTE_W * STAT_BYTES;
    localparam int CNT_W    = $clog2(STAT_BYTES);
    localparam int GAP_W    = 16;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_REQ,
        PH_RECV,
        PH_EVAL,
        PH_GAP
    } poll_phase_e;

    typedef struct packed {
        logic [STAT_W-1:0] mask;
        logic [STAT_W-1:0] expect_val;
        logic              any_mode;
        logic              auto_stop;
        logic [GAP_W-1:0]  interval;
        logic [CNT_W-1:0]  bytes_m1;
    } poll_cfg_t;

    // Bits that belong to the received bytes for a given count-minus-one
    function automatic logic [STAT_W-1:0] lane_bits(input logic [CNT_W-1:0] m1);
        logic [STAT_W-1:0] r;
        r = '0;
        for (int l = 0; l < STAT_BYTES; l++) begin
            if (l <= int'(m1)) r[l*BYTE_W +: BYTE_W] = '1;
        end
        return r;
    endfunction

endpackage

// File: rtl/stat_collect.sv
module stat_collect
    import stpoll_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 clear,
    input  logic                 take,
    input  logic [BYTE_W-1:0]    byte_in,
    input  logic [CNT_W-1:0]     bytes_m1,
    output logic [STAT_W-1:0]    value,
    output logic                 last
);
    logic [CNT_W-1:0] idx;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            idx <= '0;
        end else if (take) begin
            idx <= idx + 1'b1;
        end
    end

    for (genvar l = 0; l < STAT_BYTES; l++) begin : g_lane
        always_ff @(posedge clk) begin
            if (rst || clear) begin
                value[l*BYTE_W +: BYTE_W] <= '0;
            end else if (take && idx == CNT_W'(l)) begin
                value[l*BYTE_W +: BYTE_W] <= byte_in;
            end
        end
    end

    assign last = take && (idx == bytes_m1);

endmodule

// File: rtl/match_eval.sv
module match_eval
    import stpoll_pkg::*;
(
    input  logic [STAT_W-1:0] value,
    input  poll_cfg_t         cfg,
    output logic              hit
);
    logic [STAT_W-1:0] sel;
    logic [STAT_W-1:0] agree;

    always_comb begin
        sel   = cfg.mask & lane_bits(cfg.bytes_m1);
        agree = ~(value ^ cfg.expect_val) & sel;
        if (cfg.any_mode) begin
            hit = |agree;
        end else begin
            hit = (agree == sel);
        end
    end

endmodule

// File: rtl/poll_seq.sv
module poll_seq
    import stpoll_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              abort,
    input  logic              rd_ack,
    input  logic              last_byte,
    input  logic              hit,
    input  logic              auto_stop,
    input  logic [GAP_W-1:0]  interval,
    output poll_phase_e       phase,
    output logic              done_pulse
);
    logic [GAP_W-1:0] gap_left;
    logic             abort_held;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase      <= PH_IDLE;
            gap_left   <= '0;
            abort_held <= 1'b0;
            done_pulse <= 1'b0;
        end else begin
            done_pulse <= 1'b0;
            unique case (phase)
                PH_IDLE: begin
                    if (start) begin
                        phase      <= PH_REQ;
                        abort_held <= 1'b0;
                    end
                end
                PH_REQ: begin
                    if (rd_ack) begin
                        phase      <= PH_RECV;
                        abort_held <= abort;
                    end else if (abort) begin
                        phase      <= PH_IDLE;
                        done_pulse <= 1'b1;
                    end
                end
                PH_RECV: begin
                    if (abort) abort_held <= 1'b1;
                    if (last_byte) phase <= PH_EVAL;
                end
                PH_EVAL: begin
                    if (abort_held || abort) begin
                        phase      <= PH_IDLE;
                        done_pulse <= 1'b1;
                    end else if (hit && auto_stop) begin
                        phase <= PH_IDLE;
                    end else if (interval == '0) begin
                        phase <= PH_REQ;
                    end else begin
                        phase    <= PH_GAP;
                        gap_left <= interval;
                    end
                end
                PH_GAP: begin
                    if (abort) begin
                        phase      <= PH_IDLE;
                        done_pulse <= 1'b1;
                    end else if (gap_left == GAP_W'(1)) begin
                        phase <= PH_REQ;
                    end else begin
                        gap_left <= gap_left - 1'b1;
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/status_poller.sv
module status_poller
    import stpoll_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start,
    input  logic                 abort,
    input  logic [STAT_W-1:0]    cfg_mask,
    input  logic [STAT_W-1:0]    cfg_expect,
    input  logic                 cfg_any_mode,
    input  logic                 cfg_auto_stop,
    input  logic [GAP_W-1:0]     cfg_interval,
    input  logic [CNT_W-1:0]     cfg_bytes_m1,
    output logic                 rd_req,
    input  logic                 rd_ack,
    input  logic                 rx_valid,
    input  logic [BYTE_W-1:0]    rx_byte,
    input  logic                 match_clr,
    output logic                 match_flag,
    output logic                 busy,
    output logic                 done_pulse
);
    poll_cfg_t         cfg_q;
    poll_phase_e       phase;
    logic [STAT_W-1:0] stat_value;
    logic              last_byte;
    logic              hit;

    // Configuration frozen for the whole run
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (start && phase == PH_IDLE) begin
            cfg_q.mask       <= cfg_mask;
            cfg_q.expect_val <= cfg_expect;
            cfg_q.any_mode   <= cfg_any_mode;
            cfg_q.auto_stop  <= cfg_auto_stop;
            cfg_q.interval   <= cfg_interval;
            cfg_q.bytes_m1   <= cfg_bytes_m1;
        end
    end

    poll_seq u_seq (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .abort      (abort),
        .rd_ack     (rd_ack),
        .last_byte  (last_byte),
        .hit        (hit),
        .auto_stop  (cfg_q.auto_stop),
        .interval   (cfg_q.interval),
        .phase      (phase),
        .done_pulse (done_pulse)
    );

    stat_collect u_collect (
        .clk      (clk),
        .rst      (rst),
        .clear    (phase == PH_REQ),
        .take     (phase == PH_RECV && rx_valid),
        .byte_in  (rx_byte),
        .bytes_m1 (cfg_q.bytes_m1),
        .value    (stat_value),
        .last     (last_byte)
    );

    match_eval u_match (
        .value (stat_value),
        .cfg   (cfg_q),
        .hit   (hit)
    );

    // Sticky flag: a new match wins over a clear in the same cycle
    always_ff @(posedge clk) begin
        if (rst) begin
            match_flag <= 1'b0;
        end else if (phase == PH_EVAL && hit) begin
            match_flag <= 1'b1;
        end else if (match_clr) begin
            match_flag <= 1'b0;
        end
    end

    assign rd_req = (phase == PH_REQ);
    assign busy   = (phase != PH_IDLE);

endmodule

// File: rtl/status_poller_chk.sv
module status_poller_chk (
    input logic clk,
    input logic rst,
    input logic rd_req,
    input logic rd_ack,
    input logic abort,
    input logic match_clr,
    input logic match_flag,
    input logic busy,
    input logic done_pulse
);
    // R1: no request is ever raised outside a polling run
    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !rd_req);

    // R2: an unanswered request is held unless aborted
    assert_req_held_R2: assert property (@(posedge clk) disable iff (rst)
        (rd_req && !rd_ack && !abort) |=> rd_req);

    // R2: an acknowledged request is dropped at the next edge
    assert_req_drop_R2: assert property (@(posedge clk) disable iff (rst)
        (rd_req && rd_ack) |=> !rd_req);

    // R8: a run ends only through a match stop or an abort completion
    assert_end_cause_R8: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (match_flag || done_pulse));

    // R10: the flag holds while no clear is applied
    assert_flag_sticky_R10: assert property (@(posedge clk) disable iff (rst)
        (match_flag && !match_clr) |=> match_flag);

    // R11: completion pulse comes with idle and lasts one cycle
    assert_done_idle_R11: assert property (@(posedge clk) disable iff (rst)
        done_pulse |-> !busy);

    assert_done_single_R11: assert property (@(posedge clk) disable iff (rst)
        done_pulse |=> !done_pulse);

endmodule

bind status_poller status_poller_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .rd_req     (rd_req),
    .rd_ack     (rd_ack),
    .abort      (abort),
    .match_clr  (match_clr),
    .match_flag (match_flag),
    .busy       (busy),
    .done_pulse (done_pulse)
);

// File: tb/status_poller_tb.sv
module status_poller_tb;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0, abort = 1'b0, match_clr = 1'b0;
    logic [31:0] cfg_mask = '0, cfg_expect = '0;
    logic        cfg_any_mode = 1'b0, cfg_auto_stop = 1'b0;
    logic [15:0] cfg_interval = '0;
    logic [1:0]  cfg_bytes_m1 = '0;
    logic        rd_ack = 1'b0, rx_valid = 1'b0;
    logic [7:0]  rx_byte = '0;
    logic        rd_req, match_flag, busy, done_pulse;

    int n_tests = 0, n_fail = 0;
    int cycles = 0;
    bit finished = 1'b0;

    // responder settings
    logic [31:0] status_word = '0;
    int          ack_delay = 0;
    bit          eng_on = 1'b1;

    status_poller u_dut (
        .clk(clk), .rst(rst), .start(start), .abort(abort),
        .cfg_mask(cfg_mask), .cfg_expect(cfg_expect),
        .cfg_any_mode(cfg_any_mode), .cfg_auto_stop(cfg_auto_stop),
        .cfg_interval(cfg_interval), .cfg_bytes_m1(cfg_bytes_m1),
        .rd_req(rd_req), .rd_ack(rd_ack), .rx_valid(rx_valid), .rx_byte(rx_byte),
        .match_clr(match_clr), .match_flag(match_flag), .busy(busy),
        .done_pulse(done_pulse)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int          m_step;      // 0 idle, 1 waiting ack, 2 reading, 3 judging, 4 pausing
    int          m_got, m_left;
    bit          m_abort_seen, m_flag, m_done;
    logic [31:0] m_val;
    logic [31:0] k_mask, k_exp;
    bit          k_any, k_stop;
    int          k_gap, k_count;

    function automatic bit judge(input logic [31:0] v);
        int considered = 0, agreeing = 0;
        for (int b = 0; b < 32; b++) begin
            if (k_mask[b] && b < 8 * k_count) begin
                considered++;
                if (v[b] == k_exp[b]) agreeing++;
            end
        end
        if (k_any) return agreeing > 0;
        return agreeing == considered;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_step = 0; m_flag = 0; m_done = 0; m_abort_seen = 0;
            m_val = '0; m_got = 0; m_left = 0;
        end else begin
            bit ok;
            bit set_flag;
            set_flag = 0;
            m_done = 0;
            case (m_step)
                0: if (start) begin
                    m_step = 1; m_abort_seen = 0;
                    k_mask = cfg_mask; k_exp = cfg_expect; k_any = cfg_any_mode;
                    k_stop = cfg_auto_stop; k_gap = cfg_interval; k_count = cfg_bytes_m1 + 1;
                end
                1: if (rd_ack) begin
                    m_step = 2; m_got = 0; m_val = '0; m_abort_seen = abort;
                end else if (abort) begin
                    m_step = 0; m_done = 1;
                end
                2: begin
                    if (abort) m_abort_seen = 1;
                    if (rx_valid) begin
                        m_val[8*m_got +: 8] = rx_byte;
                        m_got++;
                        if (m_got == k_count) m_step = 3;
                    end
                end
                3: begin
                    ok = judge(m_val);
                    if (ok) set_flag = 1;
                    if (m_abort_seen || abort) begin
                        m_step = 0; m_done = 1;
                    end else if (ok && k_stop) m_step = 0;
                    else if (k_gap == 0) m_step = 1;
                    else begin m_step = 4; m_left = k_gap; end
                end
                default: begin
                    if (abort) begin m_step = 0; m_done = 1; end
                    else if (m_left == 1) m_step = 1;
                    else m_left--;
                end
            endcase
            if (set_flag) m_flag = 1;
            else if (match_clr) m_flag = 0;
        end
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (!rst && !finished) begin
            check("R2", "busy vs model", busy, (m_step != 0));
            check("R7", "rd_req vs model", rd_req, (m_step == 1));
            check("R10", "match_flag vs model", match_flag, m_flag);
            check("R11", "done_pulse vs model", done_pulse, m_done);
        end
    end

    // ---------------- command engine responder ----------------
    initial begin
        forever begin
            @(negedge clk);
            rd_ack = 0; rx_valid = 0;
            if (rd_req && eng_on) begin
                for (int d = 0; d < ack_delay; d++) @(negedge clk);
                if (rd_req) begin
                    rd_ack = 1;
                    for (int k = 0; k <= int'(cfg_bytes_m1_run); k++) begin
                        @(negedge clk);
                        rd_ack = 0; rx_valid = 1; rx_byte = status_word[8*k +: 8];
                    end
                    @(negedge clk);
                    rx_valid = 0;
                end
            end
        end
    end

    logic [1:0] cfg_bytes_m1_run = '0;

    // ---------------- helpers ----------------
    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin @(negedge clk); #1; end
    endtask

    task automatic kick();
        cfg_bytes_m1_run = cfg_bytes_m1;
        @(negedge clk); #1; start = 1;
        @(negedge clk); #1; start = 0;
    endtask

    task automatic wait_idle(input int lim);
        for (int i = 0; i < lim && busy; i++) begin @(negedge clk); #1; end
    endtask

    task automatic wait_read_end();
        for (int i = 0; i < 200 && !rx_valid; i++) begin @(negedge clk); #1; end
        for (int i = 0; i < 200 && rx_valid; i++) begin @(negedge clk); #1; end
    endtask

    task automatic pulse_abort();
        abort = 1; @(negedge clk); #1; abort = 0;
    endtask

    initial begin
        while (cycles < WATCHDOG && !finished) begin
            @(posedge clk); cycles++;
        end
        if (!finished) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    // ---------------- directed scenarios ----------------
    initial begin
        int k;
        tick(3);
        rst = 0;
        #1;
        // R1: reset state
        check("R1", "busy after reset", busy, 0);
        check("R1", "rd_req after reset", rd_req, 0);
        check("R1", "match_flag after reset", match_flag, 0);
        check("R1", "done_pulse after reset", done_pulse, 0);

        // R4 R3 R8: all-agree, 2 bytes, selected bits [11:8] of second byte
        cfg_mask = 32'h0000_0F00; cfg_expect = 32'h0000_0A00;
        cfg_any_mode = 0; cfg_auto_stop = 1; cfg_interval = 0; cfg_bytes_m1 = 2'd1;
        status_word = 32'h0000_5A33; ack_delay = 2;
        kick();
        check("R2", "busy after start", busy, 1);
        check("R2", "rd_req after start", rd_req, 1);
        wait_idle(100);
        check("R8", "auto stop ends run", busy, 0);
        check("R4", "all-agree match on byte 1 lane", match_flag, 1);

        // R10: clear
        match_clr = 1; tick(1); match_clr = 0;
        check("R10", "flag cleared", match_flag, 0);
        tick(2);
        check("R10", "flag stays cleared", match_flag, 0);

        // R7 R4 no match; interval 3; then R11 abort in pause
        cfg_mask = 32'h0000_0001; cfg_expect = 32'h0000_0001; cfg_bytes_m1 = 2'd0;
        cfg_auto_stop = 0; cfg_interval = 16'd3; status_word = 32'h0000_00FE; ack_delay = 0;
        kick();
        wait_read_end();
        k = 0;
        while (!rd_req && k < 50) begin @(negedge clk); #1; k++; end
        check("R7", "edges from last byte to next request", k, 4);
        check("R4", "all-agree mismatch keeps flag low", match_flag, 0);
        wait_read_end();
        tick(1);
        pulse_abort();
        check("R11", "idle after abort in pause", busy, 0);
        check("R11", "done pulse after abort in pause", done_pulse, 1);
        tick(1);
        check("R11", "done pulse lasts one cycle", done_pulse, 0);

        // R6: one byte, upper mask and expect bits ignored
        cfg_mask = 32'hFFFF_FF0F; cfg_expect = 32'h1234_AB05; cfg_bytes_m1 = 2'd0;
        cfg_auto_stop = 1; cfg_interval = 0; status_word = 32'h0000_0075;
        kick();
        wait_idle(100);
        check("R6", "bits above byte count ignored", match_flag, 1);
        match_clr = 1; tick(1); match_clr = 0;

        // R5: any-agree, 4 bytes, all bits disagree -> no match; R11 abort while waiting ack
        cfg_mask = 32'hFFFF_FFFF; cfg_expect = 32'hFFFF_FFFF; cfg_bytes_m1 = 2'd3;
        cfg_any_mode = 1; cfg_auto_stop = 0; cfg_interval = 16'd1; status_word = 32'h0000_0000;
        kick();
        wait_read_end();
        wait_read_end();
        check("R5", "any-agree with no agreeing bit", match_flag, 0);
        // R9: one agreeing bit in byte 1, polling continues
        status_word = 32'h0000_8000;
        wait_read_end();
        tick(2);
        check("R9", "flag set in continuous mode", match_flag, 1);
        check("R9", "still busy after match", busy, 1);
        match_clr = 1; tick(1); match_clr = 0;
        wait_read_end();
        tick(2);
        check("R9", "flag set again by later read", match_flag, 1);

        // R12: abort during a read
        for (int i = 0; i < 200 && !rx_valid; i++) begin @(negedge clk); #1; end
        pulse_abort();
        tick(3);
        check("R12", "busy until read finishes", busy, 1);
        tick(1);
        check("R12", "idle after read finished", busy, 0);
        check("R12", "done pulse after deferred abort", done_pulse, 1);

        // R2: start while idle after aborted run, any-agree with empty selection (R5)
        cfg_mask = 32'h0; cfg_auto_stop = 1; cfg_bytes_m1 = 2'd0;
        match_clr = 1; tick(1); match_clr = 0;
        eng_on = 0;
        kick();
        tick(3);
        check("R2", "request held without ack", rd_req, 1);
        eng_on = 1;
        tick(8);
        check("R5", "empty selection never matches in any mode", match_flag, 0);
        pulse_abort();
        tick(6);
        check("R11", "run ended by abort", busy, 0);

        tick(2);
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule